// File: doc/BRIEF.md
# Programmable FIFO Threshold Flag Unit

This block produces the two programmable warning flags of a dual-clock FIFO. The almost-full flag warns that the FIFO is nearly out of space, and the almost-empty flag warns that it is nearly out of data. Both flags are active low. The FIFO storage, its pointers and its full/empty logic live outside the block. The block receives the occupancy level as seen from each clock domain. The occupancy is the number of words held, counting the output register in first-word-fall-through operation.

Two offsets set the thresholds. The empty offset (n) sets the almost-empty threshold and the full offset (m) sets the almost-full threshold. Software loads them over the FIFO data bus by raising an offset-select input. A write-side pointer picks which offset register a load reaches. A separate read-side pointer picks which one a readback returns. Both pointers start at the empty offset and alternate between the two registers.

In first-word-fall-through mode both thresholds move up by one word, because the output register adds one word of capacity. Each flag can use one of two timing styles. In single-clock (synchronous) timing the flag is a register on one clock. In two-clock (asynchronous) timing the flag is asserted by one clock and released by the other.

Top module: `fifo_thresh_flags`

## Requirements
- R1: While `rst_n` is low, `paf_n` and `pae_n` are high and `off_rdata` is zero. Reset sets the empty offset to `DEF_EMPTY_OFF` and the full offset to `DEF_FULL_OFF`. Reset returns both offset pointers to the empty offset.
- R2: At a `wr_clk` rising edge with `off_sel` and `wr_en` both high, `wr_data[OFF_W-1:0]` is stored into the offset that the write pointer selects. The write pointer then moves to the other offset, so the order is empty, full, empty, and so on. An offset load must never coincide with an offset readback request.
- R3: A `wr_clk` edge with `off_sel` high and `wr_en` low changes neither offset nor the write pointer. A `wr_clk` edge with `off_sel` low changes neither offset nor the write pointer, whatever `wr_en` is.
- R4: In standard mode (`fwft_mode`=0), a `rd_clk` edge with `off_sel` and `rd_en` high loads `off_rdata` with the offset the read pointer selects, zero-extended. The read pointer then moves to the other offset, independently of the write pointer.
- R5: In first-word-fall-through mode (`fwft_mode`=1), a readback request changes neither `off_rdata` nor the read pointer.
- R6: The almost-full condition holds when the level is at least DEPTH−m in standard mode, and at least DEPTH+1−m in first-word-fall-through mode.
- R7: The almost-empty condition holds when the level is at most n in standard mode, and at most n+1 in first-word-fall-through mode.
- R8: With `paf_async`=0, `paf_n` is the inverse of the almost-full condition on `wr_level` at the previous `wr_clk` edge. `rd_level` has no effect on it.
- R9: With `paf_async`=1, a `wr_clk` edge that sees the condition on `wr_level` drives `paf_n` low. Only a `rd_clk` edge that sees the condition false on `rd_level` drives it high again.
- R10: With `pae_async`=0, `pae_n` is the inverse of the almost-empty condition on `rd_level` at the previous `rd_clk` edge. `wr_level` has no effect on it.
- R11: With `pae_async`=1, a `rd_clk` edge that sees the condition on `rd_level` drives `pae_n` low. Only a `wr_clk` edge that sees the condition false on `wr_level` drives it high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, applies to both domains |
| fwft_mode | input | 1 | 1 = first-word-fall-through, 0 = standard |
| paf_async | input | 1 | 1 = two-clock timing for the almost-full flag |
| pae_async | input | 1 | 1 = two-clock timing for the almost-empty flag |
| off_sel | input | 1 | Routes data-bus accesses to the offset registers |
| wr_en | input | 1 | Write strobe, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_data | input | DATA_W | Write data bus; the low OFF_W bits load an offset |
| wr_level | input | LVL_W | FIFO occupancy as seen in the write domain |
| rd_level | input | LVL_W | FIFO occupancy as seen in the read domain |
| off_rdata | output | DATA_W | Offset readback value |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
The thresholds are swept over every level from empty to one past the full capacity. The sweep covers both modes and both timing styles, with offset pairs at zero, at a middle value and at the maximum. This separates the one-word shift in first-word-fall-through mode from off-by-one errors at each threshold edge. Directed tests then hold the two levels at different values. These show which clock may set and which may release each flag, and that single-clock timing ignores the other domain. Offset sequences mix ignored strobes, loads and readbacks in both modes. They expose pointers that advance when they must not, or that share state between the load side and the readback side.

// File: rtl/tflag_pkg.sv
package tflag_pkg;

  // Which offset register a pointer currently selects.
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } off_ptr_e;

  // Almost-full: occupancy reaches capacity minus the full offset.
  // First-word-fall-through capacity includes one output-register word.
  function automatic logic paf_hit(int level, int depth, int full_off, logic fwft);
    return level >= (depth + int'(fwft) - full_off);
  endfunction

  // Almost-empty: occupancy at or below the empty offset (plus one in FWFT).
  function automatic logic pae_hit(int level, int empty_off, logic fwft);
    return level <= (empty_off + int'(fwft));
  endfunction

  // The pointer sequence: empty -> full -> empty ...
  function automatic off_ptr_e ptr_next(off_ptr_e p);
    return (p == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/tflag_offset_regs.sv
module tflag_offset_regs
  import tflag_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 18,
  parameter int DEF_N  = 7,
  parameter int DEF_M  = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              off_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              fwft,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFF_W-1:0]  off_n,
  output logic [OFF_W-1:0]  off_m,
  output off_ptr_e          wptr,
  output off_ptr_e          rptr,
  output logic [DATA_W-1:0] off_rdata
);
  localparam int NREG = 2;

  logic [OFF_W-1:0] regs [NREG];
  logic             load_evt;
  logic             read_evt;

  // Load only with the select and the write strobe together.
  assign load_evt = off_sel && wr_en;
  // Readback is blocked in first-word-fall-through mode.
  assign read_evt = off_sel && rd_en && !fwft;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      regs[SEL_EMPTY] <= OFF_W'(DEF_N);
      regs[SEL_FULL]  <= OFF_W'(DEF_M);
      wptr            <= SEL_EMPTY;
    end else if (load_evt) begin
      regs[wptr] <= wr_data[OFF_W-1:0];
      wptr       <= ptr_next(wptr);
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= SEL_EMPTY;
      off_rdata <= '0;
    end else if (read_evt) begin
      off_rdata <= DATA_W'(regs[rptr]);
      rptr      <= ptr_next(rptr);
    end
  end

  assign off_n = regs[SEL_EMPTY];
  assign off_m = regs[SEL_FULL];

endmodule

// File: rtl/tflag_flag_gen.sv
// One threshold flag. The assert domain sets it; in two-clock timing the
// release domain clears it. Set and clear are kept as toggles, one per
// domain, so each register has a single clock.
module tflag_flag_gen (
  input  logic a_clk,
  input  logic r_clk,
  input  logic rst_n,
  input  logic async_mode,
  input  logic a_hit,
  input  logic r_hit,
  output logic flag_n
);
  logic sync_q;
  logic a_tog;
  logic r_tog;
  logic asserted;

  assign asserted = a_tog ^ r_tog;

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      a_tog  <= 1'b0;
    end else begin
      sync_q <= a_hit;
      if (!asserted && a_hit) a_tog <= ~a_tog;
    end
  end

  always_ff @(posedge r_clk or negedge rst_n) begin
    if (!rst_n) r_tog <= 1'b0;
    else if (asserted && !r_hit) r_tog <= ~r_tog;
  end

  assign flag_n = async_mode ? !asserted : !sync_q;

endmodule

// File: rtl/fifo_thresh_flags.sv
module fifo_thresh_flags
  import tflag_pkg::*;
#(
  parameter int DEPTH         = 256,
  parameter int DATA_W        = 18,
  parameter int DEF_EMPTY_OFF = 7,
  parameter int DEF_FULL_OFF  = 7,
  parameter int LVL_W         = $clog2(DEPTH + 2)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              paf_async,
  input  logic              pae_async,
  input  logic              off_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [LVL_W-1:0]  rd_level,
  output logic [DATA_W-1:0] off_rdata,
  output logic              paf_n,
  output logic              pae_n
);
  localparam int OFF_W = $clog2(DEPTH);

  logic [OFF_W-1:0] off_n;
  logic [OFF_W-1:0] off_m;
  off_ptr_e         wptr;
  off_ptr_e         rptr;

  // Threshold conditions as seen by each domain.
  logic paf_hit_w, paf_hit_r, pae_hit_w, pae_hit_r;

  assign paf_hit_w = paf_hit(int'(wr_level), DEPTH, int'(off_m), fwft_mode);
  assign paf_hit_r = paf_hit(int'(rd_level), DEPTH, int'(off_m), fwft_mode);
  assign pae_hit_w = pae_hit(int'(wr_level), int'(off_n), fwft_mode);
  assign pae_hit_r = pae_hit(int'(rd_level), int'(off_n), fwft_mode);

  tflag_offset_regs #(
    .OFF_W (OFF_W),
    .DATA_W(DATA_W),
    .DEF_N (DEF_EMPTY_OFF),
    .DEF_M (DEF_FULL_OFF)
  ) u_offs (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .off_sel  (off_sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .fwft     (fwft_mode),
    .wr_data  (wr_data),
    .off_n    (off_n),
    .off_m    (off_m),
    .wptr     (wptr),
    .rptr     (rptr),
    .off_rdata(off_rdata)
  );

  // Almost-full: set by writes, released by reads.
  tflag_flag_gen u_paf (
    .a_clk     (wr_clk),
    .r_clk     (rd_clk),
    .rst_n     (rst_n),
    .async_mode(paf_async),
    .a_hit     (paf_hit_w),
    .r_hit     (paf_hit_r),
    .flag_n    (paf_n)
  );

  // Almost-empty: set by reads, released by writes.
  tflag_flag_gen u_pae (
    .a_clk     (rd_clk),
    .r_clk     (wr_clk),
    .rst_n     (rst_n),
    .async_mode(pae_async),
    .a_hit     (pae_hit_r),
    .r_hit     (pae_hit_w),
    .flag_n    (pae_n)
  );

endmodule

// File: rtl/tflag_chk.sv
module tflag_chk #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 18
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              fwft_mode,
  input logic              paf_async,
  input logic              pae_async,
  input logic              off_sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic              paf_n,
  input logic              pae_n,
  input logic              paf_hit_w,
  input logic              pae_hit_r,
  input logic [OFF_W-1:0]  off_n,
  input logic [OFF_W-1:0]  off_m,
  input logic              wptr,
  input logic              rptr,
  input logic [DATA_W-1:0] off_rdata
);
  logic wok, rok;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) wok <= 1'b0; else wok <= 1'b1;
  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) rok <= 1'b0; else rok <= 1'b1;

  // R1
  always @(posedge wr_clk) begin
    if (!rst_n) reset_flags_chk: assert (paf_n && pae_n && off_rdata == '0);
  end

  // R2
  no_load_during_readback_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(off_sel && wr_en && rd_en));

  // R3
  ignored_load_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wok && !(off_sel && wr_en)) |=> ($stable(off_n) && $stable(off_m) && $stable(wptr)));

  // R5
  fwft_readback_block_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rok && off_sel && rd_en && fwft_mode) |=> ($stable(off_rdata) && $stable(rptr)));

  // R8
  paf_sync_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wok && !paf_async && $past(!paf_async)) |-> (paf_n == !$past(paf_hit_w)));

  // R10
  pae_sync_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rok && !pae_async && $past(!pae_async)) |-> (pae_n == !$past(pae_hit_r)));

endmodule

bind fifo_thresh_flags tflag_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .fwft_mode(fwft_mode),
  .paf_async(paf_async),
  .pae_async(pae_async),
  .off_sel  (off_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .paf_n    (paf_n),
  .pae_n    (pae_n),
  .paf_hit_w(paf_hit_w),
  .pae_hit_r(pae_hit_r),
  .off_n    (off_n),
  .off_m    (off_m),
  .wptr     (wptr),
  .rptr     (rptr),
  .off_rdata(off_rdata)
);

// File: tb/tb_fifo_thresh_flags.sv
`timescale 1ns/100ps
module tb_fifo_thresh_flags;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int DEF_N  = 3;
  localparam int DEF_M  = 5;
  localparam int LVL_W  = $clog2(DEPTH + 2);

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic fwft_mode = 1'b0, paf_async = 1'b0, pae_async = 1'b0;
  logic off_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [LVL_W-1:0]  wr_level = '0, rd_level = '0;
  logic [DATA_W-1:0] off_rdata;
  logic paf_n, pae_n;

  int n_chk = 0, n_bad = 0;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;

  fifo_thresh_flags #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DEF_EMPTY_OFF(DEF_N), .DEF_FULL_OFF(DEF_M)
  ) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .paf_async(paf_async), .pae_async(pae_async), .off_sel(off_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .wr_level(wr_level),
    .rd_level(rd_level), .off_rdata(off_rdata), .paf_n(paf_n), .pae_n(pae_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Free space at or below m means almost full.
  function automatic int exp_paf_n(int lvl, int m, int f);
    return ((DEPTH + f - lvl) <= m) ? 0 : 1;
  endfunction
  // Words beyond the FWFT extra word at or below n means almost empty.
  function automatic int exp_pae_n(int lvl, int n, int f);
    return ((lvl - f) <= n) ? 0 : 1;
  endfunction

  task automatic settle();
    repeat (3) @(posedge wr_clk);
    repeat (3) @(posedge rd_clk);
    #0.3;
  endtask

  task automatic load_off(input int v);
    @(negedge wr_clk); off_sel = 1'b1; wr_en = 1'b1; wr_data = DATA_W'(v);
    @(negedge wr_clk); off_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic read_off();
    @(negedge rd_clk); off_sel = 1'b1; rd_en = 1'b1;
    @(negedge rd_clk); off_sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic levels(input int w, input int r);
    wr_level = LVL_W'(w); rd_level = LVL_W'(r);
    settle();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    chk("R1 paf_n in reset", int'(paf_n), 1);
    chk("R1 pae_n in reset", int'(pae_n), 1);
    chk("R1 off_rdata in reset", int'(off_rdata), 0);
    @(negedge wr_clk); rst_n = 1'b1;

    // R1 defaults and R4 readback order empty then full
    read_off(); chk("R1 R4 default n", int'(off_rdata), DEF_N);
    read_off(); chk("R1 R4 default m", int'(off_rdata), DEF_M);

    // R5: readback blocked in FWFT mode
    fwft_mode = 1'b1;
    read_off(); chk("R5 fwft data held", int'(off_rdata), DEF_M);
    fwft_mode = 1'b0;
    read_off(); chk("R5 pointer held", int'(off_rdata), DEF_N);
    read_off(); chk("R4 pointer wrap", int'(off_rdata), DEF_M);

    // R3: select without write strobe, and normal writes, leave offsets
    @(negedge wr_clk); off_sel = 1'b1; wr_data = 8'd13;
    repeat (3) @(negedge wr_clk);
    off_sel = 1'b0; wr_en = 1'b1;
    repeat (3) @(negedge wr_clk);
    wr_en = 1'b0;
    read_off(); chk("R3 n unchanged", int'(off_rdata), DEF_N);
    read_off(); chk("R3 m unchanged", int'(off_rdata), DEF_M);

    // R2: loads go empty then full; write pointer independent of read
    load_off(9); load_off(2);
    read_off(); chk("R2 n loaded", int'(off_rdata), 9);
    load_off(12);                         // write pointer back at empty
    read_off(); chk("R2 R4 m loaded", int'(off_rdata), 2);
    load_off(6);                          // full offset now 6
    read_off(); chk("R2 n reloaded", int'(off_rdata), 12);
    read_off(); chk("R2 m reloaded", int'(off_rdata), 6);

    // R6 R7 sweeps over offsets, modes and timing styles
    for (int p = 0; p < 3; p++) begin
      int nv, mv;
      nv = (p == 0) ? 3 : (p == 1) ? 0 : DEPTH - 1;
      mv = (p == 0) ? 5 : (p == 1) ? 0 : DEPTH - 1;
      load_off(nv); load_off(mv);
      for (int f = 0; f < 2; f++) begin
        for (int a = 0; a < 2; a++) begin
          fwft_mode = f[0]; paf_async = a[0]; pae_async = a[0];
          for (int l = 0; l <= DEPTH + 1; l++) begin
            levels(l, l);
            chk($sformatf("R6 paf n=%0d m=%0d f=%0d a=%0d l=%0d", nv, mv, f, a, l),
                int'(paf_n), exp_paf_n(l, mv, f));
            chk($sformatf("R7 pae n=%0d m=%0d f=%0d a=%0d l=%0d", nv, mv, f, a, l),
                int'(pae_n), exp_pae_n(l, nv, f));
          end
        end
      end
    end

    // Directed timing tests: n=3, m=5, standard; full threshold 11
    load_off(3); load_off(5);
    fwft_mode = 1'b0; paf_async = 1'b0; pae_async = 1'b0;
    levels(11, 11); chk("R8 sync set", int'(paf_n), 0);
    levels(0, 11);  chk("R8 sync follows write level", int'(paf_n), 1);
    levels(11, 0);  chk("R8 read level ignored", int'(paf_n), 0);

    paf_async = 1'b1;
    levels(11, 11); chk("R9 async set", int'(paf_n), 0);
    levels(0, 11);  chk("R9 write clock cannot release", int'(paf_n), 0);
    levels(0, 0);   chk("R9 read clock releases", int'(paf_n), 1);
    paf_async = 1'b0;

    levels(0, 0);   chk("R10 sync set", int'(pae_n), 0);
    levels(0, 8);   chk("R10 sync follows read level", int'(pae_n), 1);
    levels(8, 0);   chk("R10 write level ignored", int'(pae_n), 0);

    pae_async = 1'b1;
    levels(0, 0);   chk("R11 async set", int'(pae_n), 0);
    levels(0, 8);   chk("R11 read clock cannot release", int'(pae_n), 0);
    levels(8, 8);   chk("R11 write clock releases", int'(pae_n), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule